// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the address a fetch unit should use after the current one. The fetch PC enters the predict port and the predicted next PC comes out in the same cycle, through combinational logic only. No decoded instruction information is needed, so the prediction is ready before decode. The table is direct-mapped and has 2^k slots. Each slot holds a valid flag, an address tag and a target. When the slot selected by the PC is valid and its tag matches, the stored target is returned. In every other case the output is PC+4.

The execute stage resolves control transfers and reports each one through a one-cycle update port. The report carries the branch PC, the resolved next PC and a taken flag. Only taken transfers allocate or overwrite a slot. Not-taken transfers leave the table unchanged, and ordinary ALU and memory instructions are never reported. Either kind of instruction can still receive a target if it aliases onto a matching slot.

The lookup has no handshake. The update port has a valid strobe and no ready signal. It never applies back-pressure, and it takes one record in every cycle in which the strobe is high.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup returns lk_pc + 4 until a taken update writes a slot.
- R2: A taken update (upd_valid=1, upd_taken=1) writes the slot, and from the next cycle a lookup of the same PC returns upd_next_pc.
- R3: An update with upd_taken=0 changes nothing: existing slots keep their targets and empty slots stay empty.
- R4: A lookup whose slot is valid but holds a different tag returns lk_pc + 4.
- R5: The slot index is PC bits [k+1:2] and the tag is PC bits [31:k+2]. PC bits [1:0] play no part in the match, and slots with different indices are independent.
- R6: If a lookup and a taken update address the same slot in the same cycle, the lookup returns the old contents. The new contents are returned from the next cycle.
- R7: A taken update to an already-valid slot replaces both its tag and its target, so the previous PC then misses.
- R8: With upd_valid=0 nothing is written, whatever the values of upd_taken, upd_pc and upd_next_pc.
- R9: lk_next_pc follows a change of lk_pc within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all valid flags |
| lk_pc | input | ADDR_W | Fetch PC to look up |
| lk_next_pc | output | ADDR_W | Predicted next PC (combinational) |
| upd_valid | input | 1 | Resolution record present this cycle |
| upd_pc | input | ADDR_W | PC of the resolved control transfer |
| upd_next_pc | input | ADDR_W | Resolved next PC |
| upd_taken | input | 1 | The transfer was taken |

## Verification
The checker runs on every cycle. It checks that a taken write is visible on the following cycle to a lookup of the same PC, and that the same slot index with another tag then gives PC+4. It also checks that a cycle without a taken write leaves the prediction for an unchanged PC as it was, and that the first cycle after reset predicts PC+4. The bench sweeps every index with two tags. Only the bench covers PC bits [1:0] being ignored, a not-taken or unstrobed record having no effect, the old value being returned when a lookup and a write collide, and overwrite and re-reset behaviour.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic {
    LK_MISS = 1'b0,
    LK_HIT  = 1'b1
  } btb_hit_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - 2 - IDX_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_lo;
  assign unused_lo = ^pc[1:0];
  assign idx = pc[IDX_W+1:2];
  assign tag = pc[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_tgt
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[e] <= wr_tag;
        tgt_mem[e] <= wr_tgt;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_tgt   = tgt_mem[rd_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [TAG_W-1:0]  pc_tag,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_tgt,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  btb_hit_e hit;

  always_comb begin
    hit = (rd_valid && (rd_tag == pc_tag)) ? LK_HIT : LK_MISS;
    case (hit)
      LK_HIT:  next_pc = rd_tgt;
      default: next_pc = pc + STEP;
    endcase
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - 2 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_next_pc,
  input  logic              upd_taken
);
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_tgt;
  logic              wr_en;

  assign wr_en = upd_valid && upd_taken;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_up (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag)
  );

  btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_next_pc),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
  );

  btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_lookup (
    .pc(lk_pc), .pc_tag(lk_tag), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_tgt(rd_tgt), .next_pc(lk_next_pc)
  );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [ADDR_W-1:0] lk_next_pc,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_next_pc,
  input logic              upd_taken
);
  localparam int LO = 2;
  localparam int HI = IDX_W + 2;

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lk_next_pc == lk_pc + ADDR_W'(4)));

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      ((lk_pc[ADDR_W-1:LO] != $past(upd_pc[ADDR_W-1:LO])) ||
       (lk_next_pc == $past(upd_next_pc))));

  assert_other_tag_misses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      ((lk_pc[HI-1:LO] != $past(upd_pc[HI-1:LO])) ||
       (lk_pc[ADDR_W-1:HI] == $past(upd_pc[ADDR_W-1:HI])) ||
       (lk_next_pc == lk_pc + ADDR_W'(4))));

  assert_no_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_taken) |=>
      ((lk_pc != $past(lk_pc)) || (lk_next_pc == $past(lk_next_pc))));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
  localparam int AW = 32;
  localparam int K  = 6;
  localparam int N  = 1 << K;
  localparam logic [23:0] TAGA = 24'h00A5C3;
  localparam logic [23:0] TAGB = 24'h0F0F11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic [AW-1:0] lk_next_pc;
  logic upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_next_pc = '0;
  logic upd_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_next_pc(lk_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_next_pc(upd_next_pc),
    .upd_taken(upd_taken)
  );

  function automatic logic [AW-1:0] mkpc(logic [23:0] t, int i, logic [1:0] lo);
    return {t, i[K-1:0], lo};
  endfunction

  function automatic logic [AW-1:0] tgt(int i, int salt);
    return 32'h8000_0100 + 32'(i * 16) + 32'(salt << 20);
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [AW-1:0] pc, logic [AW-1:0] exp);
    lk_pc = pc;
    #2;
    check(req, lk_next_pc, exp);
  endtask

  task automatic update(logic v, logic [AW-1:0] pc, logic [AW-1:0] nx, logic tk);
    @(negedge clk);
    upd_valid = v; upd_pc = pc; upd_next_pc = nx; upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0; upd_taken = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++)
      look("R1 empty table", mkpc(TAGA, i, 2'b00), mkpc(TAGA, i, 2'b00) + 4);

    for (int i = 0; i < N; i++) update(1'b1, mkpc(TAGA, i, 2'b00), tgt(i, 1), 1'b1);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      look("R2 hit after write", mkpc(TAGA, i, 2'b00), tgt(i, 1));
      look("R5 low pc bits ignored", mkpc(TAGA, i, 2'b11), tgt(i, 1));
    end
    for (int i = 0; i < N; i++)
      look("R4 tag mismatch", mkpc(TAGB, i, 2'b00), mkpc(TAGB, i, 2'b00) + 4);

    update(1'b1, mkpc(TAGA, 3, 2'b01), tgt(3, 2), 1'b1);
    @(negedge clk);
    look("R5 write with low bits set", mkpc(TAGA, 3, 2'b00), tgt(3, 2));
    look("R5 neighbour slot intact", mkpc(TAGA, 4, 2'b00), tgt(4, 1));

    update(1'b1, mkpc(TAGB, 5, 2'b00), tgt(5, 3), 1'b0);
    @(negedge clk);
    look("R3 not-taken keeps old", mkpc(TAGA, 5, 2'b00), tgt(5, 1));
    look("R3 not-taken no alloc", mkpc(TAGB, 5, 2'b00), mkpc(TAGB, 5, 2'b00) + 4);

    update(1'b0, mkpc(TAGB, 6, 2'b00), tgt(6, 4), 1'b1);
    @(negedge clk);
    look("R8 no strobe keeps old", mkpc(TAGA, 6, 2'b00), tgt(6, 1));
    look("R8 no strobe no alloc", mkpc(TAGB, 6, 2'b00), mkpc(TAGB, 6, 2'b00) + 4);

    @(negedge clk);
    lk_pc = mkpc(TAGA, 7, 2'b00);
    upd_valid = 1'b1; upd_pc = mkpc(TAGA, 7, 2'b00); upd_next_pc = tgt(7, 5); upd_taken = 1'b1;
    #2;
    check("R6 old value same cycle", lk_next_pc, tgt(7, 1));
    @(posedge clk);
    #2;
    check("R6 new value next cycle", lk_next_pc, tgt(7, 5));
    @(negedge clk);
    upd_valid = 1'b0; upd_taken = 1'b0;

    update(1'b1, mkpc(TAGB, 9, 2'b00), tgt(9, 6), 1'b1);
    @(negedge clk);
    look("R7 overwrite new tag hits", mkpc(TAGB, 9, 2'b00), tgt(9, 6));
    look("R7 overwrite old tag misses", mkpc(TAGA, 9, 2'b00), mkpc(TAGA, 9, 2'b00) + 4);

    @(negedge clk);
    lk_pc = mkpc(TAGA, 10, 2'b00);
    #1;
    lk_pc = mkpc(TAGB, 10, 2'b00);
    #1;
    check("R9 combinational miss", lk_next_pc, mkpc(TAGB, 10, 2'b00) + 4);
    lk_pc = mkpc(TAGA, 10, 2'b00);
    #1;
    check("R9 combinational hit", lk_next_pc, tgt(10, 1));

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++)
      look("R1 re-reset clears", mkpc(TAGA, i, 2'b00), mkpc(TAGA, i, 2'b00) + 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule